// File: doc/BRIEF.md
# Auto-Baud Serial Boot Handshake Controller

After reset, this controller sits between an idle-high asynchronous serial receive line and a serial transmit line. It has no preset bit rate. The host sends a stream of all-zero characters. The controller times how long the line stays low for each of them and derives the bit period in clock cycles. It then runs its own 8N1 transmitter and receiver at that period.

Once two consecutive low periods agree, the controller transmits one all-zero character at the derived rate as an acknowledgement. It then waits for a single 0x55 reply. The correct reply moves it to a done state. In that state every later correctly framed byte comes out on a one-cycle strobe with its data. Any other reply, or a reply with a broken stop bit, locks the controller in a failed state until the next reset. There are no retries.

Top module: `autobaud_boot_ctrl`

## Requirements
- R1: Both lines use 8N1 framing, least significant data bit first, with no inversion and logic high as idle. `txd_o` stays high at all times except while the acknowledgement character is being sent.
- R2: `state_o` encodes the phase as 0 settling, 1 measuring, 2 sending the acknowledgement, 3 waiting for the reply, 4 done and 5 failed. The controller spends SETTLE_CYC cycles in phase 0 after reset release, and low pulses during that time are not measured.
- R3: A low width W is the number of clock cycles the line stays low. The bit period is (W + 4) / 9 with integer division, which is W/9 rounded to the nearest integer. W is the second of two consecutive accepted low widths whose difference is at most the first width shifted right by TOL_SHIFT. This period appears on `bit_period_o` and does not change afterwards.
- R4: A low width below 9 cycles, or one that reaches the saturating counter limit of 2^CNT_W - 1, discards any pending first width. Measuring then starts over.
- R5: Once the period is accepted, the controller sends exactly one 0x00 character at that period, so `txd_o` is low for 9 x period cycles and then returns high.
- R6: In phase 3, a received byte equal to 0x55 with a high stop bit moves the controller to phase 4 and raises `done_o`. Phase 4 holds until reset.
- R7: In phase 3, a received byte other than 0x55, or a zero stop bit, moves the controller to phase 5 and raises `fail_o`. Phase 5 holds until reset and ignores all later traffic.
- R8: In phase 4, each correctly framed byte received at the derived period produces a single-cycle `byte_valid_o` pulse with the byte on `byte_o`. The 0x55 reply itself is not strobed.
- R9: When two consecutive widths disagree beyond the tolerance, nothing is accepted. The newer width becomes the reference for the next comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rxd_i | input | 1 | Serial receive line from host, idle high |
| txd_o | output | 1 | Serial transmit line to host, idle high |
| state_o | output | 3 | Phase code, see R2 |
| done_o | output | 1 | Handshake completed |
| fail_o | output | 1 | Handshake failed, held until reset |
| bit_period_o | output | CNT_W | Derived bit period in clock cycles |
| byte_o | output | DATA_BITS | Last byte received after completion |
| byte_valid_o | output | 1 | One-cycle strobe for `byte_o` |

## Verification
The bench sends zero-character low pulses during the settling time. A controller that measures too early would lock onto those pulses and leave phase 1. It sends a glitch shorter than nine cycles between two good widths, and a width beyond the saturation limit. A controller that kept a stale first width would accept one character too soon. It uses low widths of 103 and 104 cycles to pin the rounding: a truncating divider would report 11 instead of 12 for the second. It also sends a disagreeing pair to check that nothing is accepted. It sends a wrong reply, a 0x55 with a zero stop bit, and a correct 0x55 sent after failure. A controller that retried, or that ignored the stop bit, would leave phase 5 or never enter it.

// File: rtl/abb_pkg.sv
package abb_pkg;

  typedef enum logic [2:0] {
    ST_SETTLE   = 3'd0,
    ST_MEASURE  = 3'd1,
    ST_SEND_ACK = 3'd2,
    ST_WAIT_REP = 3'd3,
    ST_DONE     = 3'd4,
    ST_FAILED   = 3'd5
  } abb_state_e;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } abb_rx_e;

endpackage

// File: rtl/abb_reset_sync.sv
module abb_reset_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/abb_low_meter.sv
module abb_low_meter #(
  parameter int CNT_W     = 20,
  parameter int DATA_BITS = 8,
  parameter int TOL_SHIFT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             rx_i,
  output logic             ok_o,
  output logic [CNT_W-1:0] period_o
);
  localparam int              ZERO_BITS = DATA_BITS + 1;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] MIN_LOW  = CNT_W'(ZERO_BITS);
  localparam logic [CNT_W:0]   DIVISOR  = (CNT_W+1)'(ZERO_BITS);
  localparam logic [CNT_W:0]   HALF_DIV = (CNT_W+1)'(ZERO_BITS / 2);

  logic             prev_q, prev_n;
  logic             cnting_q, cnting_n;
  logic             have_q, have_n;
  logic             ok_q, ok_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] first_q, first_n;
  logic [CNT_W-1:0] per_q, per_n;
  logic [CNT_W-1:0] diff;
  logic [CNT_W:0]   rsum;
  logic             bad_w, agree_w;

  always_comb begin
    diff    = (cnt_q > first_q) ? (cnt_q - first_q) : (first_q - cnt_q);
    agree_w = diff <= (first_q >> TOL_SHIFT);
    bad_w   = (cnt_q < MIN_LOW) || (cnt_q == CNT_MAX);
    rsum    = {1'b0, cnt_q} + HALF_DIV;
  end

  always_comb begin
    prev_n   = prev_q;
    cnting_n = cnting_q;
    have_n   = have_q;
    cnt_n    = cnt_q;
    first_n  = first_q;
    per_n    = per_q;
    ok_n     = 1'b0;
    if (!en_i) begin
      prev_n   = 1'b0;
      cnting_n = 1'b0;
      have_n   = 1'b0;
      cnt_n    = '0;
    end else begin
      prev_n = rx_i;
      if (prev_q && !rx_i) begin
        cnting_n = 1'b1;
        cnt_n    = CNT_ONE;
      end else if (cnting_q && !rx_i) begin
        if (cnt_q != CNT_MAX) cnt_n = cnt_q + CNT_ONE;
      end else if (cnting_q && rx_i) begin
        cnting_n = 1'b0;
        if (bad_w) begin
          have_n = 1'b0;
        end else if (!have_q) begin
          have_n  = 1'b1;
          first_n = cnt_q;
        end else if (agree_w) begin
          have_n = 1'b0;
          ok_n   = 1'b1;
          per_n  = CNT_W'(rsum / DIVISOR);
        end else begin
          first_n = cnt_q;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      cnting_q <= 1'b0;
      have_q   <= 1'b0;
      ok_q     <= 1'b0;
      cnt_q    <= '0;
      first_q  <= '0;
      per_q    <= '0;
    end else begin
      prev_q   <= prev_n;
      cnting_q <= cnting_n;
      have_q   <= have_n;
      ok_q     <= ok_n;
      cnt_q    <= cnt_n;
      first_q  <= first_n;
      per_q    <= per_n;
    end
  end

  assign ok_o     = ok_q;
  assign period_o = per_q;

  // R3
  period_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ok_o |-> (period_o != '0));

  // R4
  ok_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ok_o |-> $past(en_i));
endmodule

// File: rtl/abb_uart_tx.sv
module abb_uart_tx #(
  parameter int CNT_W     = 20,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [DATA_BITS-1:0] data_i,
  input  logic [CNT_W-1:0]     period_i,
  output logic                 txd_o,
  output logic                 done_o
);
  localparam int              FRAME_BITS = DATA_BITS + 2;
  localparam int              BIT_W      = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(FRAME_BITS - 1);
  localparam logic [BIT_W-1:0] BIT_ONE   = BIT_W'(1);

  logic                  busy_q, busy_n;
  logic                  done_q, done_n;
  logic [FRAME_BITS-1:0] sh_q, sh_n;
  logic [CNT_W-1:0]      cnt_q, cnt_n;
  logic [BIT_W-1:0]      bit_q, bit_n;

  always_comb begin
    busy_n = busy_q;
    sh_n   = sh_q;
    cnt_n  = cnt_q;
    bit_n  = bit_q;
    done_n = 1'b0;
    if (!busy_q) begin
      if (start_i) begin
        busy_n = 1'b1;
        sh_n   = {1'b1, data_i, 1'b0};
        cnt_n  = period_i - CNT_ONE;
        bit_n  = '0;
      end
    end else if (cnt_q != '0) begin
      cnt_n = cnt_q - CNT_ONE;
    end else if (bit_q == LAST_BIT) begin
      busy_n = 1'b0;
      done_n = 1'b1;
    end else begin
      sh_n  = {1'b1, sh_q[FRAME_BITS-1:1]};
      bit_n = bit_q + BIT_ONE;
      cnt_n = period_i - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sh_q   <= '1;
      cnt_q  <= '0;
      bit_q  <= '0;
    end else begin
      busy_q <= busy_n;
      done_q <= done_n;
      sh_q   <= sh_n;
      cnt_q  <= cnt_n;
      bit_q  <= bit_n;
    end
  end

  assign txd_o  = busy_q ? sh_q[0] : 1'b1;
  assign done_o = done_q;

  // R5
  start_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_q) |=> !txd_o);
endmodule

// File: rtl/abb_uart_rx.sv
module abb_uart_rx
  import abb_pkg::*;
#(
  parameter int CNT_W     = 20,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_i,
  input  logic                 rx_i,
  input  logic [CNT_W-1:0]     period_i,
  output logic                 valid_o,
  output logic                 ferr_o,
  output logic [DATA_BITS-1:0] data_o
);
  localparam int              BIT_W    = $clog2(DATA_BITS);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_BITS - 1);
  localparam logic [BIT_W-1:0] BIT_ONE  = BIT_W'(1);

  abb_rx_e              st_q, st_n;
  logic [CNT_W-1:0]     cnt_q, cnt_n;
  logic [BIT_W-1:0]     bit_q, bit_n;
  logic [DATA_BITS-1:0] sh_q, sh_n;
  logic [DATA_BITS-1:0] data_q, data_n;
  logic                 valid_q, valid_n;
  logic                 ferr_q, ferr_n;

  always_comb begin
    st_n    = st_q;
    cnt_n   = cnt_q;
    bit_n   = bit_q;
    sh_n    = sh_q;
    data_n  = data_q;
    valid_n = 1'b0;
    ferr_n  = 1'b0;
    if (!en_i) begin
      st_n  = RX_IDLE;
      cnt_n = '0;
    end else if (st_q == RX_IDLE) begin
      if (!rx_i) begin
        st_n  = RX_START;
        cnt_n = period_i >> 1;
      end
    end else if (cnt_q != '0) begin
      cnt_n = cnt_q - CNT_ONE;
    end else begin
      cnt_n = period_i - CNT_ONE;
      case (st_q)
        RX_START: begin
          bit_n = '0;
          st_n  = rx_i ? RX_IDLE : RX_DATA;
        end
        RX_DATA: begin
          sh_n = {rx_i, sh_q[DATA_BITS-1:1]};
          if (bit_q == LAST_BIT) st_n = RX_STOP;
          else                   bit_n = bit_q + BIT_ONE;
        end
        default: begin
          st_n = RX_IDLE;
          if (rx_i) begin
            valid_n = 1'b1;
            data_n  = sh_q;
          end else begin
            ferr_n = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      st_q    <= st_n;
      cnt_q   <= cnt_n;
      bit_q   <= bit_n;
      sh_q    <= sh_n;
      data_q  <= data_n;
      valid_q <= valid_n;
      ferr_q  <= ferr_n;
    end
  end

  assign valid_o = valid_q;
  assign ferr_o  = ferr_q;
  assign data_o  = data_q;

  // R1
  stop_high_on_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(rx_i));

  // R7
  stop_low_on_ferr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ferr_o |-> !$past(rx_i));
endmodule

// File: rtl/autobaud_boot_ctrl.sv
module autobaud_boot_ctrl
  import abb_pkg::*;
#(
  parameter int                   CNT_W      = 20,
  parameter int                   DATA_BITS  = 8,
  parameter int                   SETTLE_CYC = 100,
  parameter int                   TOL_SHIFT  = 5,
  parameter logic [DATA_BITS-1:0] REPLY_CODE = 'h55
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rxd_i,
  output logic                 txd_o,
  output logic [2:0]           state_o,
  output logic                 done_o,
  output logic                 fail_o,
  output logic [CNT_W-1:0]     bit_period_o,
  output logic [DATA_BITS-1:0] byte_o,
  output logic                 byte_valid_o
);
  localparam int              SET_W    = $clog2(SETTLE_CYC + 1);
  localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE_CYC - 1);
  localparam logic [SET_W-1:0] SET_ONE  = SET_W'(1);

  logic                 rst_s_n;
  logic [1:0]           rx_sync_q;
  logic                 rx_s;
  abb_state_e           state_q, state_n;
  logic [SET_W-1:0]     settle_q, settle_n;
  logic [CNT_W-1:0]     per_q, per_n;
  logic                 ack_q, ack_n;
  logic                 tx_start;
  logic                 meas_ok, tx_done, rx_valid, rx_ferr;
  logic [CNT_W-1:0]     meas_per;
  logic [DATA_BITS-1:0] rx_data;
  logic                 meas_en, rx_en;

  abb_reset_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_s_n)
  );

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) rx_sync_q <= 2'b11;
    else          rx_sync_q <= {rx_sync_q[0], rxd_i};
  end
  assign rx_s = rx_sync_q[1];

  assign meas_en = (state_q == ST_MEASURE);
  assign rx_en   = (state_q == ST_WAIT_REP) || (state_q == ST_DONE);

  abb_low_meter #(.CNT_W(CNT_W), .DATA_BITS(DATA_BITS), .TOL_SHIFT(TOL_SHIFT)) u_meter (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .en_i     (meas_en),
    .rx_i     (rx_s),
    .ok_o     (meas_ok),
    .period_o (meas_per)
  );

  abb_uart_tx #(.CNT_W(CNT_W), .DATA_BITS(DATA_BITS)) u_tx (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .start_i  (tx_start),
    .data_i   ('0),
    .period_i (per_q),
    .txd_o    (txd_o),
    .done_o   (tx_done)
  );

  abb_uart_rx #(.CNT_W(CNT_W), .DATA_BITS(DATA_BITS)) u_rx (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .en_i     (rx_en),
    .rx_i     (rx_s),
    .period_i (per_q),
    .valid_o  (rx_valid),
    .ferr_o   (rx_ferr),
    .data_o   (rx_data)
  );

  always_comb begin
    state_n  = state_q;
    settle_n = settle_q;
    per_n    = per_q;
    ack_n    = ack_q;
    tx_start = 1'b0;
    case (state_q)
      ST_SETTLE: begin
        settle_n = settle_q + SET_ONE;
        if (settle_q == SET_LAST) state_n = ST_MEASURE;
      end
      ST_MEASURE: begin
        if (meas_ok) begin
          per_n   = meas_per;
          state_n = ST_SEND_ACK;
        end
      end
      ST_SEND_ACK: begin
        if (!ack_q) begin
          tx_start = 1'b1;
          ack_n    = 1'b1;
        end else if (tx_done) begin
          state_n = ST_WAIT_REP;
        end
      end
      ST_WAIT_REP: begin
        if (rx_valid) state_n = (rx_data == REPLY_CODE) ? ST_DONE : ST_FAILED;
        else if (rx_ferr) state_n = ST_FAILED;
      end
      default: state_n = state_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q  <= ST_SETTLE;
      settle_q <= '0;
      per_q    <= '0;
      ack_q    <= 1'b0;
    end else begin
      state_q  <= state_n;
      settle_q <= settle_n;
      per_q    <= per_n;
      ack_q    <= ack_n;
    end
  end

  assign state_o      = state_q;
  assign done_o       = (state_q == ST_DONE);
  assign fail_o       = (state_q == ST_FAILED);
  assign bit_period_o = per_q;
  assign byte_o       = rx_data;
  assign byte_valid_o = rx_valid && (state_q == ST_DONE);

  // R7
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q == ST_FAILED) |=> (state_q == ST_FAILED));

  // R6
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q == ST_DONE) |=> (state_q == ST_DONE));

  // R3
  period_frozen_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q != ST_MEASURE) |=> $stable(per_q));
endmodule

// File: tb/sim_autobaud_boot_ctrl.sv
module sim_autobaud_boot_ctrl;
  localparam int CW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rxd = 1'b1;
  logic          txd;
  logic [2:0]    st;
  logic          done, fail, bval;
  logic [CW-1:0] per;
  logic [7:0]    bdat;

  int     n_chk = 0;
  int     n_fail = 0;
  int     rel_cnt = 0;
  int     prev_st = 0;
  byte    got[$];
  bit     finished = 1'b0;

  always #2 clk = ~clk;

  autobaud_boot_ctrl #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .txd_o(txd), .state_o(st),
    .done_o(done), .fail_o(fail), .bit_period_o(per), .byte_o(bdat),
    .byte_valid_o(bval)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock reference comparison
  always @(negedge clk) begin
    if (!rst_n) begin
      rel_cnt = 0;
      prev_st = 0;
    end else begin
      rel_cnt++;
      check(txd == 1'b1 || st == 3'd2, "R1 txd idle high outside ack", txd, 1);
      check(!bval || st == 3'd4, "R8 strobe only when done", st, 4);
      check(done == (st == 3'd4), "R6 done flag", done, st == 3'd4);
      check(fail == (st == 3'd5), "R7 fail flag", fail, st == 3'd5);
      if (prev_st == 4 || prev_st == 5)
        check(st == prev_st, "R6/R7 terminal phase held", st, prev_st);
      if (rel_cnt < 90)
        check(st == 3'd0, "R2 settling phase", st, 0);
      if (bval) got.push_back(bdat);
      prev_st = st;
    end
  end

  task automatic hold(input bit v, input int n);
    rxd = v;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic low_pulse(input int w, input int gap);
    hold(1'b0, w);
    hold(1'b1, gap);
  endtask

  task automatic send_byte(input logic [7:0] d, input int p, input bit stop);
    hold(1'b0, p);
    for (int i = 0; i < 8; i++) hold(d[i], p);
    hold(stop, p);
    hold(1'b1, 2 * p);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    rxd = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    got.delete();
  endtask

  task automatic wait_state(input int s, input int maxc, input string req);
    int c = 0;
    while (st != s && c < maxc) begin
      @(negedge clk);
      c++;
    end
    check(st == s, req, st, s);
  endtask

  task automatic meas_tx(input int exp_w, input string req);
    int c = 0;
    int w = 0;
    while (txd == 1'b1 && c < 2000) begin
      @(negedge clk);
      c++;
    end
    while (txd == 1'b0 && w < 4000) begin
      @(negedge clk);
      w++;
    end
    check(w == exp_w, req, w, exp_w);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // Scenario A: settle, glitch, rounding up, success, following bytes
    do_reset();
    @(negedge clk);
    check(txd == 1 && st == 0 && !done && !fail && per == 0, "R2 reset state", st, 0);
    @(posedge clk); #1;
    hold(1'b1, 5);
    low_pulse(20, 10);
    low_pulse(20, 10);
    while (rel_cnt < 115) @(negedge clk);
    check(st == 3'd1, "R2 pulses during settling ignored", st, 1);
    @(posedge clk); #1;
    low_pulse(104, 20);
    low_pulse(5, 20);
    low_pulse(104, 20);
    check(st == 3'd1, "R4 short glitch restarts measurement", st, 1);
    hold(1'b0, 104);
    hold(1'b1, 1);
    meas_tx(108, "R5 ack low width 9x12");
    check(per == 12, "R3 period from width 104", per, 12);
    wait_state(3, 200, "R5 wait reply after ack");
    @(posedge clk); #1;
    send_byte(8'h55, 12, 1'b1);
    wait_state(4, 50, "R6 reply accepted");
    check(got.size() == 0, "R8 reply byte not strobed", got.size(), 0);
    send_byte(8'hA7, 12, 1'b1);
    send_byte(8'h3C, 12, 1'b1);
    repeat (5) @(negedge clk);
    check(got.size() == 2, "R8 two bytes strobed", got.size(), 2);
    if (got.size() == 2) begin
      check(got[0] == 8'hA7, "R8 first byte", got[0], 8'hA7);
      check(got[1] == 8'h3C, "R8 second byte", got[1], 8'h3C);
    end

    // Scenario B: disagreeing pair, wrong reply, no retry
    do_reset();
    while (rel_cnt < 110) @(negedge clk);
    @(posedge clk); #1;
    low_pulse(90, 20);
    low_pulse(100, 20);
    check(st == 3'd1, "R9 disagreeing widths not accepted", st, 1);
    hold(1'b0, 100);
    hold(1'b1, 1);
    meas_tx(99, "R5 ack low width 9x11");
    check(per == 11, "R9 newer width is reference", per, 11);
    wait_state(3, 200, "R5 wait reply after ack B");
    @(posedge clk); #1;
    send_byte(8'hAA, 11, 1'b1);
    wait_state(5, 50, "R7 wrong reply fails");
    @(posedge clk); #1;
    send_byte(8'h55, 11, 1'b1);
    repeat (20) @(negedge clk);
    check(st == 3'd5, "R7 no retry after failure", st, 5);
    check(got.size() == 0, "R7 no strobe after failure", got.size(), 0);

    // Scenario C: saturation, rounding down, framing error
    do_reset();
    while (rel_cnt < 110) @(negedge clk);
    @(posedge clk); #1;
    low_pulse(103, 20);
    low_pulse(1100, 20);
    low_pulse(103, 20);
    check(st == 3'd1, "R4 saturated width restarts measurement", st, 1);
    hold(1'b0, 103);
    hold(1'b1, 1);
    meas_tx(99, "R5 ack low width C");
    check(per == 11, "R3 period from width 103", per, 11);
    wait_state(3, 200, "R5 wait reply after ack C");
    @(posedge clk); #1;
    send_byte(8'h55, 11, 1'b0);
    wait_state(5, 50, "R7 zero stop bit fails");
    check(fail == 1'b1, "R7 fail flag raised", fail, 1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule